// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Register Bank

This block is the software-facing side of a 64-source interrupt controller. It samples 64 level-sensitive interrupt lines every clock into a pending vector and keeps the programmable state: a control word, a 5-bit normal-request threshold, per-source enable and type bits (normal or fast), and a 4-bit priority for every source. From that state it drives two request lines, one for normal and one for fast interrupts. It also answers reads of two vector registers that name the source a handler should serve.

Software reaches the bank through a word-addressed bus with separate read and write strobes. Read data is registered, so it appears one cycle after the address. Reading a vector register that names a source also acknowledges that source: its pending bit clears on the same edge that captures the read data. Enables can be set in bulk through high and low words, or one at a time by number. A force register lets software overwrite half of the pending vector.

Top module: `irq_regbank`

## Requirements
- R1: After reset all pending, enable, type, control and priority state is zero and the threshold (word 1) reads 0x1F.
- R2: The control word (word 0) keeps only bits 18, 19, 20, 21, 22 and 24 of written data; every other bit reads zero.
- R3: The threshold (word 1) is 5 bits wide. A write to word 2 sets the enable bit numbered by data bits [5:0], and a write to word 3 clears that enable bit. Words 2 and 3 read as zero.
- R4: Enable bits for sources 63..32 sit in word 4 and those for 31..0 in word 5. Type bits sit in word 6 (high) and word 7 (low), where a 1 marks a fast source. All four words are read/write.
- R5: Priority word at offset 15−k holds sources 8k..8k+7, with source i in bits [4(i mod 8)+3 : 4(i mod 8)]. The words read back as written.
- R6: Each cycle the pending bit of a source takes the level of its input. Raw pending reads at word 18 (high) and 19 (low). Enabled normal pending reads at words 22 and 23, and enabled fast pending at words 24 and 25.
- R7: A write to word 20 (high) or word 21 (low) replaces that half of the pending vector for one cycle, after which pending follows the inputs again. Words 20 and 21 read as zero.
- R8: fiq_req is high when any enabled fast source is pending. A read of word 17 returns the lowest-numbered such source, or 0xFFFFFFFF when there is none.
- R9: irq_req is high when an enabled normal source is pending and either the threshold is 0x1F or that source's priority is greater than the threshold.
- R10: A read of word 16 returns the enabled pending normal source with the highest priority, with ties going to the higher source number. The source number is in bits [31:16] and the priority in bits [15:0]. With no such source the read returns 0xFFFFFFFF.
- R11: A vector read that names a source clears that source's pending bit on the read edge, and this takes precedence over the input. A source whose input stays high becomes pending again on the next cycle.
- R12: Read data appears one cycle after a read strobe and holds otherwise. Word 0x40 reads 4 and other unmapped words read 0. Writes to words 16–19, 22–25 and to unmapped words change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; vector reads acknowledge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 64 | Level interrupt inputs |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
The bench sets up two normal sources at equal priority. A design that broke ties toward the lower number would return the wrong source from word 16. It holds a fast source high through an acknowledge and reads raw pending on the following two cycles. A design whose acknowledge did nothing would show the bit still set; one whose acknowledge stuck would never show it again. It also places a priority exactly on the threshold and tests the 0x1F threshold, which lets even a priority-0 source through. An off-by-one compare or a missing special case shows up as a wrong irq_req. Finally, it checks that a forced pending value lasts exactly one cycle and that the split high/low words land in the correct half.

// File: rtl/irq_regbank.sv
module irq_regbank #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       irq_src,
  output logic              irq_req,
  output logic              fiq_req
);
  localparam int NSRC = 64;
  localparam int PW   = 4;
  localparam logic [31:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [4:0]  MASK_OPEN = 5'h1F;
  localparam logic [31:0] NO_VEC    = 32'hFFFF_FFFF;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DISN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ENH  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ENL  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TYH  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_TYL  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_NVEC = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_FVEC = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_RAWH = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] A_RAWL = ADDR_W'(19);
  localparam logic [ADDR_W-1:0] A_FRCH = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_FRCL = ADDR_W'(21);
  localparam logic [ADDR_W-1:0] A_NPH  = ADDR_W'(22);
  localparam logic [ADDR_W-1:0] A_NPL  = ADDR_W'(23);
  localparam logic [ADDR_W-1:0] A_FPH  = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_FPL  = ADDR_W'(25);
  localparam logic [ADDR_W-1:0] A_V0   = ADDR_W'(64);

  logic [31:0]      ctrl_q;
  logic [4:0]       mask_q;
  logic [NSRC-1:0]  en_q, type_q, pend_q, pend_nxt;
  logic [NSRC*PW-1:0] prio_q;

  logic [NSRC-1:0] nflag, fflag;
  assign nflag = pend_q & en_q & ~type_q;
  assign fflag = pend_q & en_q & type_q;

  logic          n_found, n_over, f_found;
  logic [5:0]    n_idx, f_idx;
  logic [PW-1:0] n_pri;

  always_comb begin
    n_found = 1'b0; n_over = 1'b0; n_idx = '0; n_pri = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (nflag[i]) begin
        if (!n_found || prio_q[PW*i +: PW] >= n_pri) begin
          n_found = 1'b1;
          n_idx   = 6'(i);
          n_pri   = prio_q[PW*i +: PW];
        end
        if ({1'b0, prio_q[PW*i +: PW]} > mask_q) n_over = 1'b1;
      end
    end
  end

  always_comb begin
    f_found = 1'b0; f_idx = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (fflag[i]) begin
        f_found = 1'b1;
        f_idx   = 6'(i);
      end
    end
  end

  assign irq_req = (|nflag) && (mask_q == MASK_OPEN || n_over);
  assign fiq_req = |fflag;

  logic is_prio;
  logic [2:0] pword;
  assign is_prio = (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(1));
  assign pword   = ~bus_addr[2:0];

  logic ack_n, ack_f;
  assign ack_n = bus_re && bus_addr == A_NVEC && n_found;
  assign ack_f = bus_re && bus_addr == A_FVEC && f_found;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (is_prio) rd_val = prio_q[32*pword +: 32];
    else begin
      case (bus_addr)
        A_CTRL: rd_val = ctrl_q;
        A_MASK: rd_val = {27'd0, mask_q};
        A_ENH:  rd_val = en_q[63:32];
        A_ENL:  rd_val = en_q[31:0];
        A_TYH:  rd_val = type_q[63:32];
        A_TYL:  rd_val = type_q[31:0];
        A_NVEC: rd_val = n_found ? {10'd0, n_idx, 12'd0, n_pri} : NO_VEC;
        A_FVEC: rd_val = f_found ? {26'd0, f_idx} : NO_VEC;
        A_RAWH: rd_val = pend_q[63:32];
        A_RAWL: rd_val = pend_q[31:0];
        A_NPH:  rd_val = nflag[63:32];
        A_NPL:  rd_val = nflag[31:0];
        A_FPH:  rd_val = fflag[63:32];
        A_FPL:  rd_val = fflag[31:0];
        A_V0:   rd_val = 32'd4;
        default: rd_val = '0;
      endcase
    end
  end

  always_comb begin
    pend_nxt = irq_src;
    if (bus_we && bus_addr == A_FRCH) pend_nxt[63:32] = bus_wdata;
    if (bus_we && bus_addr == A_FRCL) pend_nxt[31:0]  = bus_wdata;
    if (ack_n) pend_nxt[n_idx] = 1'b0;
    if (ack_f) pend_nxt[f_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mask_q    <= MASK_OPEN;
      en_q      <= '0;
      type_q    <= '0;
      pend_q    <= '0;
      prio_q    <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (bus_re) bus_rdata <= rd_val;
      if (bus_we) begin
        if (is_prio) prio_q[32*pword +: 32] <= bus_wdata;
        case (bus_addr)
          A_CTRL: ctrl_q <= bus_wdata & CTRL_KEEP;
          A_MASK: mask_q <= bus_wdata[4:0];
          A_ENN:  en_q[bus_wdata[5:0]] <= 1'b1;
          A_DISN: en_q[bus_wdata[5:0]] <= 1'b0;
          A_ENH:  en_q[63:32] <= bus_wdata;
          A_ENL:  en_q[31:0]  <= bus_wdata;
          A_TYH:  type_q[63:32] <= bus_wdata;
          A_TYL:  type_q[31:0]  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic [63:0]       irq_src,
  input logic [63:0]       pend_q,
  input logic              irq_req,
  input logic              fiq_req
);
  p_ctrl_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(0) |=> (bus_rdata & ~32'h017C_0000) == 32'd0);

  p_mask_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(1) |=> bus_rdata[31:5] == 27'd0);

  p_num_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3)) |=> bus_rdata == 32'd0);

  p_force_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (bus_addr == ADDR_W'(20) || bus_addr == ADDR_W'(21)) |=> bus_rdata == 32'd0);

  p_quiet_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_src) == 64'd0 && !$past(bus_we) |-> !irq_req && !fiq_req);

  p_fvec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(17) |=> bus_rdata == 32'hFFFF_FFFF || bus_rdata < 32'd64);

  p_nvec_format_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(16) |=>
      bus_rdata == 32'hFFFF_FFFF || (bus_rdata[31:22] == 10'd0 && bus_rdata[15:4] == 12'd0));

  p_fack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(17) |=> bus_rdata == 32'hFFFF_FFFF || !pend_q[bus_rdata[5:0]]);

  p_nack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(16) |=> bus_rdata == 32'hFFFF_FFFF || !pend_q[bus_rdata[21:16]]);

  p_word40_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == ADDR_W'(64) |=> bus_rdata == 32'd4);

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind irq_regbank irq_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .irq_src(irq_src), .pend_q(pend_q),
  .irq_req(irq_req), .fiq_req(fiq_req));

// File: tb/irq_regbank_tb_top.sv
module irq_regbank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [63:0] irq_src = '0;
  logic irq_req, fiq_req;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_regbank dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_req(irq_req), .fiq_req(fiq_req));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_addr = 10'(a); bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = 10'(a); bus_re = 1'b1; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_re = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 mask", 1, 32'h1F);
    rd_chk("R1 ctrl", 0, 32'h0);
    rd_chk("R1 enable low", 5, 32'h0);
    rd_chk("R1 prio word", 8, 32'h0);
    check("R1 requests", {30'd0, irq_req, fiq_req}, 32'd0);
  endtask

  task automatic t_ctrl();
    wr(0, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl kept bits", 0, 32'h017C_0000);
  endtask

  task automatic t_enable_num();
    wr(2, 32'h45);
    rd_chk("R3 enable by number", 5, 32'h20);
    wr(2, 32'h3F);
    rd_chk("R3 enable bit 63", 4, 32'h8000_0000);
    wr(3, 32'hC5);
    rd_chk("R3 disable by number", 5, 32'h0);
    rd_chk("R3 word2 reads zero", 2, 32'h0);
    rd_chk("R3 word3 reads zero", 3, 32'h0);
    wr(1, 32'hFFFF_FFE3);
    rd_chk("R3 mask width", 1, 32'h03);
  endtask

  task automatic t_fast_ack();
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    wr(7, 32'h30);
    rd_chk("R4 type low", 7, 32'h30);
    irq_src = 64'h30; idle();
    check("R8 fiq_req", {31'd0, fiq_req}, 32'd1);
    rd_chk("R6 fast pending low", 25, 32'h30);
    rd_chk("R6 normal pending low", 23, 32'h0);
    rd_chk("R8 fast vector lowest", 17, 32'd4);
    rd_chk("R11 ack clears bit", 19, 32'h20);
    rd_chk("R11 level re-pends", 19, 32'h30);
    irq_src = '0; idle();
    rd_chk("R8 fast vector empty", 17, 32'hFFFF_FFFF);
  endtask

  task automatic t_normal_vec();
    wr(7, 32'h0);
    wr(1, 32'h0);
    wr(15, 32'h0000_5000);
    wr(14, 32'h0000_0500);
    wr(10, 32'h0000_0002);
    rd_chk("R5 prio readback", 15, 32'h0000_5000);
    irq_src = (64'd1 << 3) | (64'd1 << 10) | (64'd1 << 40); idle();
    check("R9 irq_req above mask", {31'd0, irq_req}, 32'd1);
    rd_chk("R10 tie to higher number", 16, 32'h000A_0005);
    irq_src = 64'd1 << 40; idle();
    rd_chk("R10 lone source", 16, 32'h0028_0002);
    irq_src = '0; idle();
    rd_chk("R10 empty vector", 16, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    irq_src = 64'd1 << 40; idle();
    wr(1, 32'd2);
    check("R9 prio equal to mask blocked", {31'd0, irq_req}, 32'd0);
    wr(1, 32'd1);
    check("R9 prio above mask", {31'd0, irq_req}, 32'd1);
    irq_src = 64'd1; wr(1, 32'd0);
    check("R9 prio 0 blocked", {31'd0, irq_req}, 32'd0);
    wr(1, 32'h1F);
    check("R9 open mask passes", {31'd0, irq_req}, 32'd1);
    irq_src = '0; idle();
  endtask

  task automatic t_force();
    wr(21, 32'h1);
    rd_chk("R7 force low", 19, 32'h1);
    rd_chk("R7 force one cycle", 19, 32'h0);
    wr(20, 32'h8000_0000);
    rd_chk("R7 force high", 18, 32'h8000_0000);
    rd_chk("R7 word20 reads zero", 20, 32'h0);
    rd_chk("R7 word21 reads zero", 21, 32'h0);
  endtask

  task automatic t_ignored();
    wr(64, 32'hFF); wr(96, 32'hFFFF_FFFF);
    wr(18, 32'hFFFF_FFFF); wr(19, 32'hFFFF_FFFF);
    wr(22, 32'hFFFF_FFFF); wr(16, 32'hFFFF_FFFF);
    rd_chk("R12 word 0x40", 64, 32'd4);
    rd_chk("R12 unmapped", 65, 32'h0);
    rd_chk("R12 unmapped 26", 26, 32'h0);
    rd_chk("R12 raw pending untouched", 19, 32'h0);
    rd_chk("R12 enable untouched", 5, 32'hFFFF_FFFF);
    rd_chk("R12 type untouched", 7, 32'h0);
    check("R12 rdata holds", bus_rdata, 32'h0);
  endtask

  task automatic t_high();
    wr(6, 32'h2);
    wr(8, 32'hABCD_1234);
    rd_chk("R5 top prio word", 8, 32'hABCD_1234);
    irq_src = (64'd1 << 33) | (64'd1 << 40); idle();
    rd_chk("R6 fast pending high", 24, 32'h2);
    rd_chk("R6 normal pending high", 22, 32'h100);
    rd_chk("R8 fast vector high half", 17, 32'd33);
    irq_src = '0; idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset(); t_ctrl(); t_enable_num(); t_fast_ack();
    t_normal_vec(); t_mask(); t_force(); t_ignored(); t_high();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule